// File: doc/BRIEF.md
# Cascaded Preset Modulus Counter

This block is a synchronous up-counter. It is made from identical 4-bit binary stages that are joined into one wider count register, two stages and 8 bits by default. Every stage has a synchronous clear, a synchronous parallel load and two count enables. A stage advances only when both of its enables are high. Its carry output rises when the stage is all ones and its chain enable is high, and that carry feeds the chain enable of the next stage. All stages run on the same clock edge. No carry is ever used as a clock.

A two-bit mode input selects the cycle length:

- **Mode 00** runs the full binary range.
- **Mode 01** reloads a preset of 63 when the count reaches 255, which gives 193 states.
- **Mode 10** clears the count after it reaches 192, which also gives 193 states.
- **Mode 11** runs only the lowest stage as a divide-by-12 whose top bit is a square wave at one twelfth of the clock.

A terminal-count pulse marks the last state of each cycle. The block is used as a programmable clock-enable divider or as a state sequencer.

Top module: `cascade_modcnt`

## Requirements
- R1: When `rst` is 1 or `clr_n` is 0 at a rising edge, `count` is 0 after that edge, whatever the mode or enable.
- R2: In mode 00 with `cnt_en` high, `count` rises by one per clock and wraps from 255 to 0.
- R3: With `cnt_en` low, no clear active and mode other than 11, `count` holds its value.
- R4: In mode 00 the upper nibble changes only at an edge where the lower nibble was 1111 and `cnt_en` was high.
- R5: In mode 01 an enabled edge at count 255 loads 63, and otherwise the count increments. The cycle length is 193 clocks.
- R6: In mode 10 an enabled edge at count 192 gives 0, and otherwise the count increments. The cycle length is 193 clocks.
- R7: In mode 11 the upper nibble is forced to 0 at every edge. When enabled, the lower nibble steps through 2..7 and then 10..15: a low nibble of x111 loads {~bit3, 010}. Bit 3 has a period of 12 clocks and is high for 6 of them.
- R8: `tc` is high exactly when `cnt_en` is high and `count` equals the last state of the mode: 255 in modes 00 and 01, 192 in mode 10, and 15 in mode 11.
- R9: A clear requested through `clr_n` wins over a preset load that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low clear |
| mode | input | 2 | Modulus select (00 full, 01 preset, 10 clear, 11 divide-by-12) |
| cnt_en | input | 1 | Count enable |
| count | output | 8 | Current count value |
| tc | output | 1 | Terminal-count pulse |

## Verification
The clear and the preset load can be requested in the same cycle. This happens when `clr_n` goes low exactly when the count sits at 255 in mode 01. The bench sets up that collision on purpose and requires the next count to be 0, not 63. The same holds for the enable and the wrap condition: `cnt_en` is dropped exactly on the terminal state, and the count must then hold with `tc` low. A bench model predicts every cycle, and random traffic with rare clears mixes these collisions into long runs.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        MODE_FULL   = 2'b00,
        MODE_PRESET = 2'b01,
        MODE_CLEAR  = 2'b10,
        MODE_DIV12  = 2'b11
    } mode_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic enp;
        logic ent;
    } stage_ctl_t;

    // Next load value for the 12-state low stage sequence 2..7, 10..15.
    function automatic logic [NIB_W-1:0] div12_jump(input logic [NIB_W-1:0] q);
        return {~q[NIB_W-1], 3'b010};
    endfunction

endpackage

// File: rtl/modcnt_stage.sv
module modcnt_stage
    import modcnt_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  stage_ctl_t   ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rco
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (ctl.clr)
            q_r <= '0;
        else if (ctl.ld)
            q_r <= d;
        else if (ctl.enp && ctl.ent)
            q_r <= q_r + 1'b1;
    end

    assign q   = q_r;
    assign rco = ctl.ent && (q_r == {W{1'b1}});

    p_clear_r1: assert property (@(posedge clk) ctl.clr |=> (q == '0))
        else $error("stage clear did not zero the stage");

    p_load_r5: assert property (@(posedge clk) disable iff (ctl.clr)
        ctl.ld |=> (q == $past(d)))
        else $error("stage load did not capture data");

    p_hold_r3: assert property (@(posedge clk) disable iff (ctl.clr)
        (!ctl.ld && !(ctl.enp && ctl.ent)) |=> $stable(q))
        else $error("stage moved without enables");

endmodule

// File: rtl/modcnt_ctrl.sv
module modcnt_ctrl
    import modcnt_pkg::*;
#(
    parameter int N_STG  = 2,
    parameter int PRESET = 63,
    parameter int CLR_AT = 192
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_n,
    input  mode_e                  mode,
    input  logic                   cnt_en,
    input  logic [N_STG*NIB_W-1:0] count,
    input  logic [N_STG-1:0]       rco,
    output stage_ctl_t             ctl [N_STG],
    output logic [N_STG*NIB_W-1:0] ld_data,
    output logic                   tc
);

    localparam int                   CW      = N_STG * NIB_W;
    localparam logic [CW-1:0]        ALL_ONE = {CW{1'b1}};
    localparam logic [CW-1:0]        PRE_V   = CW'(PRESET);
    localparam logic [CW-1:0]        CLR_V   = CW'(CLR_AT);
    localparam logic [CW-1:0]        DIV_TOP = CW'({NIB_W{1'b1}});

    logic          hard_clr;
    logic          preset_ld;
    logic          wrap_clr;
    logic          div_mode;
    logic          div_ld;
    logic [CW-1:0] last_v;

    assign hard_clr  = rst || !clr_n;
    assign div_mode  = (mode == MODE_DIV12);
    assign preset_ld = (mode == MODE_PRESET) && cnt_en && (count == ALL_ONE);
    assign wrap_clr  = (mode == MODE_CLEAR)  && cnt_en && (count == CLR_V);
    assign div_ld    = div_mode && cnt_en && (count[NIB_W-2:0] == {(NIB_W-1){1'b1}});

    always_comb begin
        unique case (mode)
            MODE_CLEAR: last_v = CLR_V;
            MODE_DIV12: last_v = DIV_TOP;
            default:    last_v = ALL_ONE;
        endcase
    end

    assign tc = cnt_en && (count == last_v);

    always_comb begin
        ld_data = PRE_V;
        if (div_mode)
            ld_data = {{(CW-NIB_W){1'b0}}, div12_jump(count[NIB_W-1:0])};
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_STG; gi++) begin : g_ctl
            if (gi == 0) begin : g_low
                assign ctl[gi].clr = hard_clr || wrap_clr;
                assign ctl[gi].ld  = preset_ld || div_ld;
                assign ctl[gi].enp = 1'b1;
                assign ctl[gi].ent = cnt_en;
            end else begin : g_high
                assign ctl[gi].clr = hard_clr || wrap_clr || div_mode;
                assign ctl[gi].ld  = preset_ld;
                assign ctl[gi].enp = cnt_en;
                assign ctl[gi].ent = rco[gi-1];
            end
        end
    endgenerate

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && preset_ld) |=> (count == '0))
        else $error("load won over clear");

    p_tc_last_r8: assert property (@(posedge clk) disable iff (hard_clr)
        (tc && mode == MODE_CLEAR) |=> (count == '0))
        else $error("clear mode did not wrap after terminal count");

endmodule

// File: rtl/cascade_modcnt.sv
module cascade_modcnt
    import modcnt_pkg::*;
#(
    parameter int N_STAGES = 2,
    parameter int PRESET   = 63,
    parameter int CLR_AT   = 192
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_n,
    input  logic [1:0]                mode,
    input  logic                      cnt_en,
    output logic [N_STAGES*NIB_W-1:0] count,
    output logic                      tc
);

    localparam int CW = N_STAGES * NIB_W;

    mode_e         mode_q;
    stage_ctl_t    ctl [N_STAGES];
    logic [CW-1:0] ld_data;
    logic [CW-1:0] q_all;
    logic [N_STAGES-1:0] rco;

    assign mode_q = mode_e'(mode);

    modcnt_ctrl #(
        .N_STG (N_STAGES),
        .PRESET(PRESET),
        .CLR_AT(CLR_AT)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .mode   (mode_q),
        .cnt_en (cnt_en),
        .count  (q_all),
        .rco    (rco),
        .ctl    (ctl),
        .ld_data(ld_data),
        .tc     (tc)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_STAGES; gi++) begin : g_stage
            modcnt_stage #(.W(NIB_W)) u_stage (
                .clk(clk),
                .ctl(ctl[gi]),
                .d  (ld_data[gi*NIB_W +: NIB_W]),
                .q  (q_all[gi*NIB_W +: NIB_W]),
                .rco(rco[gi])
            );
        end
    endgenerate

    assign count = q_all;

    p_reset_r1: assert property (@(posedge clk) (rst || !clr_n) |=> (count == '0))
        else $error("reset or clear did not zero the count");

    p_preset_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (tc && mode_q == MODE_PRESET) |=> (count == CW'(PRESET)))
        else $error("preset not loaded after terminal count");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (!cnt_en && mode_q != MODE_DIV12) |=> $stable(count))
        else $error("count moved while disabled");

    p_div_high_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DIV12) |=> (count[CW-1:NIB_W] == '0))
        else $error("upper stages active in divide-by-12 mode");

endmodule

// File: tb/cascade_modcnt_bench.sv
`timescale 1ns/100ps
module cascade_modcnt_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] count;
    logic       tc;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_cnt = 8'd0;
    logic [7:0] prev_cnt = 8'd0;
    logic       prev_en = 1'b0;
    logic       prev_clr = 1'b1;
    logic [1:0] prev_mode = 2'b00;
    int cyc = 0;
    int last_tc_cyc = -1;
    int tc_gap = 0;

    cascade_modcnt u_cascade_modcnt (
        .clk(clk), .rst(rst), .clr_n(clr_n), .mode(mode),
        .cnt_en(cnt_en), .count(count), .tc(tc)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] model_next(logic [7:0] c, logic r, logic cn,
                                              logic en, logic [1:0] md);
        logic [3:0] lo;
        if (r || !cn) return 8'd0;
        if (md == 2'b11) begin
            lo = c[3:0];
            if (en) lo = (lo[2:0] == 3'b111) ? {~lo[3], 3'b010} : lo + 4'd1;
            return {4'd0, lo};
        end
        if (!en) return c;
        case (md)
            2'b01:   return (c == 8'd255) ? 8'd63 : c + 8'd1;
            2'b10:   return (c == 8'd192) ? 8'd0  : c + 8'd1;
            default: return c + 8'd1;
        endcase
    endfunction

    function automatic logic model_tc(logic [7:0] c, logic en, logic [1:0] md);
        logic [7:0] last;
        case (md)
            2'b10:   last = 8'd192;
            2'b11:   last = 8'd15;
            default: last = 8'd255;
        endcase
        return en && (c == last);
    endfunction

    function automatic string req_of(logic r, logic cn, logic en, logic [1:0] md);
        if (r || !cn) return "R1";
        if (md == 2'b11) return "R7";
        if (!en) return "R3";
        case (md)
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, expv, $time);
        end
    endtask

    // One clock: check the count from the previous edge, drive new inputs, check tc.
    task automatic step(input logic r, input logic cn, input logic en, input logic [1:0] md);
        @(negedge clk);
        chk(count == exp_cnt, req_of(prev_clr ? 1'b0 : 1'b1, 1'b1, prev_en, prev_mode),
            count, exp_cnt);
        // R4: upper nibble only moves on a low-nibble carry in full mode
        if (prev_clr && prev_mode == 2'b00 && count[7:4] != prev_cnt[7:4] && count != 8'd0)
            chk(prev_en && prev_cnt[3:0] == 4'hF, "R4", count, prev_cnt);
        rst = r; clr_n = cn; cnt_en = en; mode = md;
        #1;
        chk(tc == model_tc(exp_cnt, en, md), "R8", tc, model_tc(exp_cnt, en, md));
        if (tc) begin
            if (last_tc_cyc >= 0) tc_gap = cyc - last_tc_cyc;
            last_tc_cyc = cyc;
        end
        prev_cnt  = exp_cnt;
        prev_en   = en;
        prev_clr  = !r && cn;
        prev_mode = md;
        exp_cnt   = model_next(exp_cnt, r, cn, en, md);
        cyc++;
    endtask

    task automatic measure_period(input logic [1:0] md, input int want, input string req);
        step(1'b1, 1'b1, 1'b0, md);
        last_tc_cyc = -1;
        tc_gap = 0;
        for (int i = 0; i < 2 * want + 260; i++) step(1'b0, 1'b1, 1'b1, md);
        chk(tc_gap == want, req, tc_gap, want);
    endtask

    initial begin
        int hi_cnt;
        void'($urandom(32'd20240611));
        step(1'b1, 1'b1, 1'b0, 2'b00);
        step(1'b1, 1'b1, 1'b0, 2'b00);
        @(negedge clk);
        chk(count == 8'd0, "R1", count, 0);
        chk(tc == 1'b0, "R8", tc, 0);

        // Cycle lengths per mode
        measure_period(2'b00, 256, "R2");
        measure_period(2'b01, 193, "R5");
        measure_period(2'b10, 193, "R6");
        measure_period(2'b11, 12, "R7");

        // R7: bit 3 high for 6 of 12 clocks
        hi_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b1, 1'b1, 2'b11);
            if (count[3]) hi_cnt++;
        end
        chk(hi_cnt == 6, "R7", hi_cnt, 6);

        // R9: clear collides with the preset load at 255
        step(1'b1, 1'b1, 1'b0, 2'b01);
        while (exp_cnt != 8'd255) step(1'b0, 1'b1, 1'b1, 2'b01);
        step(1'b0, 1'b0, 1'b1, 2'b01);
        @(negedge clk);
        chk(count == 8'd0, "R9", count, 0);

        // R3: enable dropped on the terminal state of clear mode
        while (exp_cnt != 8'd192) step(1'b0, 1'b1, 1'b1, 2'b10);
        step(1'b0, 1'b1, 1'b0, 2'b10);
        chk(tc == 1'b0, "R3", tc, 0);
        step(1'b0, 1'b1, 1'b0, 2'b10);
        chk(count == 8'd192, "R3", count, 192);

        // Constrained random traffic
        for (int blk = 0; blk < 40; blk++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            for (int i = 0; i < 400; i++) begin
                step(($urandom_range(0, 199) == 0),
                     ($urandom_range(0, 63) != 0),
                     ($urandom_range(0, 7) != 0), md);
            end
        end
        @(negedge clk);
        chk(count == exp_cnt, "R2", count, exp_cnt);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #900000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule